// File: doc/BRIEF.md
# Sequence Step Qualifier

This block decides when one step of a power-up or power-down sequence has finished. A sequencing state machine points it at one signal from a bank of single-bit inputs, which may be supply-good flags or plain logic levels. It says whether that signal must be high or low, and it can ask for the level to be held for a number of timebase ticks. When the level has held long enough, the block raises `step_done` for exactly one clock. The state machine then moves on and pulses `state_entry`, which clears the block for the next step.

A bypass mode treats the watched level as always met. A step can then be a pure wait, or an immediate jump when the hold is zero. The timer counts only in clock cycles where the `tick` enable is high. `tick` is meant to come from a 10 µs timebase, so hold values of 1 to 40000 cover 10 µs to 400 ms. A hold of zero qualifies on the first cycle in which the level is seen.

Top module: `step_qualifier`

## Requirements
- R1: The watched bit is `sig_in[sel_idx]`, where index 0 is the LSB. Levels on every other bit of `sig_in` have no effect on `step_done`.
- R2: When `invert` is 0 the watched bit must be 1. When `invert` is 1 the watched bit must be 0.
- R3: Consider a condition that holds from the first clock edge after a state-entry edge, with `tick` high on every cycle. For `hold_ticks` = H, `step_done` is high in the cycle that follows edge H+1 after the state-entry edge. It is low after each earlier edge.
- R4: If the condition is false at any clock edge, the hold count returns to zero. A full H ticks of unbroken condition are then needed again.
- R5: The hold count advances only on edges where `tick` is 1. A hold of 0 needs no tick.
- R6: When `force_advance` is 1, the input level is treated as met whatever the values of `sig_in` and `invert`. The hold delay still applies.
- R7: A state-entry edge (`state_entry` = 1) clears the hold count, the done output and the issued flag. This re-arms the block, and qualification restarts from zero.
- R8: `step_done` is exactly one clock wide. It is not raised again while the condition stays true, until the next state entry or reset.
- R9: A synchronous active-low reset (`rst_n` = 0) leaves `step_done` low and clears the hold count and the issued flag.
- R10: A hold of 40000 ticks is supported. With `tick` high every cycle, done appears after edge 40001 and not after edge 40000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per 10 µs |
| state_entry | input | 1 | Clears and re-arms the block at the start of a sequence state |
| sel_idx | input | SEL_W (4) | Index of the watched input |
| invert | input | 1 | 1 requires a low level, 0 requires a high level |
| force_advance | input | 1 | Ignore the input level and treat the condition as met |
| hold_ticks | input | HOLD_W (16) | Number of ticks the condition must hold |
| sig_in | input | NUM_INPUTS (16) | Bank of supply-good and logic inputs |
| step_done | output | 1 | One-cycle pulse when the step has qualified |

## Verification
Two events can fall on the same edge: the hold count reaching its target, or being cleared, while the condition drops out or a state entry arrives. The bench provokes this in three ways: it drops the watched input for one cycle in the middle of a hold, it pulses `state_entry` part way through a count, and it pulses reset part way through a count. In each case the bench predicts the edge on which `step_done` must now rise, counting from the restart, and it fails any earlier or later pulse. It also fails any second pulse within the observation window.

// File: rtl/ssq_pkg.sv
// Package: shared constants and the handshake type for the sequence step qualifier.
// Assumes a 10 us timebase tick, so the longest hold is 400 ms.
package ssq_pkg;

    // Largest hold count the timer must reach (400 ms of 10 us ticks).
    localparam int unsigned HOLD_MAX_TICKS = 40000;

    // Status passed from the hold timer to the done pulse stage.
    typedef struct packed {
        logic qualified;   // condition has held for the requested ticks
        logic cond_now;    // condition seen in the current cycle
    } qual_s;

endpackage

// File: rtl/ssq_input_select.sv
// Module: ssq_input_select
// Picks one bit out of the input bank, applies the polarity choice and
// the bypass. The output is combinational.
// Assumes: an index at or above NUM_INPUTS reads as a low level.
module ssq_input_select #(
    parameter int NUM_INPUTS = 16,
    parameter int SEL_W      = 4
) (
    input  logic [NUM_INPUTS-1:0] sig_in,
    input  logic [SEL_W-1:0]      sel_idx,
    input  logic                  invert,
    input  logic                  force_advance,
    output logic                  cond_met
);

    logic [NUM_INPUTS-1:0] hit;
    logic                  picked;

    // One decode line per input; only the indexed line passes its bit.
    for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_dec
        assign hit[gi] = (sel_idx == SEL_W'(gi)) & sig_in[gi];
    end

    // Collapse the decoded lines into the watched level, then apply polarity and bypass.
    always_comb begin
        picked   = |hit;
        cond_met = force_advance | (picked ^ invert);
    end

endmodule

// File: rtl/ssq_hold_timer.sv
// Module: ssq_hold_timer
// Counts timebase ticks while the step condition stays true. The count
// restarts whenever the condition drops, and it stops at the hold target.
// Assumes: hold_ticks stays stable while a state is active.
module ssq_hold_timer
    import ssq_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tick,
    input  logic              cond_met,
    input  logic [HOLD_W-1:0] hold_ticks,
    output qual_s             status
);

    logic [HOLD_W-1:0] cnt_q;

    // Hold counter: clears on reset, state entry or a dropped condition; otherwise counts ticks up to the target.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !cond_met) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < hold_ticks)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Condition has held for the full target count in this cycle.
    always_comb begin
        status.cond_now  = cond_met;
        status.qualified = cond_met && (cnt_q >= hold_ticks);
    end

    // R4: a dropped condition zeroes the count on the next edge.
    p_glitch_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_met) |=> (cnt_q == '0));

    // R7: state entry zeroes the count.
    p_entry_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R5: without a tick the count does not move while the condition holds.
    p_tick_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && cond_met) |=> $stable(cnt_q));

endmodule

// File: rtl/ssq_done_pulse.sv
// Module: ssq_done_pulse
// Turns the qualified level into a single-cycle pulse. An issued flag
// blocks any repeat until state entry or reset.
module ssq_done_pulse
    import ssq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  qual_s status,
    output logic  step_done
);

    logic issued_q;

    // Issued flag: set once a step has qualified, dropped on reset or state entry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            issued_q <= 1'b0;
        end else if (status.qualified) begin
            issued_q <= 1'b1;
        end
    end

    // Done pulse: high for the one cycle after the first qualified cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            step_done <= 1'b0;
        end else begin
            step_done <= status.qualified && !issued_q;
        end
    end

    // R8: the pulse never lasts two cycles.
    p_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    // R7: state entry removes any pending pulse.
    p_entry_kills_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !step_done);

endmodule

// File: rtl/step_qualifier.sv
// Module: step_qualifier (top)
// Decides when one power-sequence step is complete. The chain is
// select/invert/bypass, then the tick-counted hold timer, then a one-shot
// done pulse.
// Assumes: tick is a one-cycle enable from a 10 us timebase, and the
// configuration inputs stay stable for the life of a state.
module step_qualifier
    import ssq_pkg::*;
#(
    parameter int NUM_INPUTS = 16,
    parameter int MAX_HOLD   = HOLD_MAX_TICKS,
    localparam int SEL_W     = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1,
    localparam int HOLD_W    = $clog2(MAX_HOLD + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  state_entry,
    input  logic [SEL_W-1:0]      sel_idx,
    input  logic                  invert,
    input  logic                  force_advance,
    input  logic [HOLD_W-1:0]     hold_ticks,
    input  logic [NUM_INPUTS-1:0] sig_in,
    output logic                  step_done
);

    logic  cond_met;
    qual_s status;

    ssq_input_select #(
        .NUM_INPUTS (NUM_INPUTS),
        .SEL_W      (SEL_W)
    ) u_select (
        .sig_in        (sig_in),
        .sel_idx       (sel_idx),
        .invert        (invert),
        .force_advance (force_advance),
        .cond_met      (cond_met)
    );

    ssq_hold_timer #(
        .HOLD_W (HOLD_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state_entry),
        .tick       (tick),
        .cond_met   (cond_met),
        .hold_ticks (hold_ticks),
        .status     (status)
    );

    ssq_done_pulse u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_entry),
        .status    (status),
        .step_done (step_done)
    );

    // R3: a pulse is only issued after a cycle that had met the hold.
    p_done_after_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> $past(status.qualified));

    // R6: under bypass the select stage always reports the condition met.
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_advance |-> cond_met);

endmodule

// File: tb/tb_step_qualifier.sv
module tb_step_qualifier;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic [3:0]  sel;
        logic        inv;
        logic        frc;
        logic [15:0] hold;
        logic [15:0] sig;
        logic [15:0] lat;   // expected edge of done after state entry, 0 = never
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0, 1'b0, 16'd0,  16'h0008, 16'd1},   // R1 R2 watched bit high
        '{4'd3,  1'b0, 1'b0, 16'd0,  16'hFFF7, 16'd0},   // R1 other bits ignored
        '{4'd3,  1'b1, 1'b0, 16'd0,  16'hFFF7, 16'd1},   // R2 inverted, low required
        '{4'd3,  1'b1, 1'b0, 16'd0,  16'h0008, 16'd0},   // R2 inverted, high fails
        '{4'd15, 1'b0, 1'b0, 16'd4,  16'h8000, 16'd5},   // R3 hold 4
        '{4'd0,  1'b0, 1'b1, 16'd0,  16'h0000, 16'd1},   // R6 bypass immediate
        '{4'd0,  1'b0, 1'b1, 16'd6,  16'h0000, 16'd7},   // R6 bypass with delay
        '{4'd7,  1'b0, 1'b0, 16'd12, 16'h0080, 16'd13}   // R3 hold 12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        state_entry = 1'b0;
    logic [3:0]  sel_idx = '0;
    logic        invert = 1'b0;
    logic        force_advance = 1'b0;
    logic [15:0] hold_ticks = '0;
    logic [15:0] sig_in = '0;
    logic        step_done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_qualifier dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .state_entry   (state_entry),
        .sel_idx       (sel_idx),
        .invert        (invert),
        .force_advance (force_advance),
        .hold_ticks    (hold_ticks),
        .sig_in        (sig_in),
        .step_done     (step_done)
    );

    // Watchdog: an expired run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Mode 0 plain, 1 one-cycle dropout, 2 late tick, 3 state entry mid-hold, 4 reset mid-hold.
    task automatic run_case(input string req, input logic [3:0] s, input logic iv,
                            input logic fa, input logic [15:0] h, input logic [15:0] sg,
                            input int exp_first, input int window, input int mode);
        int first = 0;
        int pulses = 0;
        @(negedge clk);
        sel_idx = s; invert = iv; force_advance = fa; hold_ticks = h; sig_in = sg;
        tick = (mode != 2);
        state_entry = 1'b1;
        @(negedge clk);
        state_entry = 1'b0;
        for (int c = 1; c <= window; c++) begin
            @(negedge clk);
            if (step_done) begin
                pulses++;
                if (first == 0) first = c;
            end
            if (mode == 1 && c == 3) sig_in = '0;
            if (mode == 1 && c == 4) sig_in = sg;
            if (mode == 2 && c == 8) tick = 1'b1;
            if (mode == 3 && c == 2) state_entry = 1'b1;
            if (mode == 3 && c == 3) state_entry = 1'b0;
            if (mode == 4 && c == 1) rst_n = 1'b0;
            if (mode == 4 && c == 2) rst_n = 1'b1;
        end
        check({req, " done edge"}, first, exp_first);
        check({req, " pulse count R8"}, pulses, (exp_first == 0) ? 0 : 1);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 reset output", int'(step_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", int'(step_done), 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            run_case($sformatf("vector %0d", v), VECS[v].sel, VECS[v].inv, VECS[v].frc,
                     VECS[v].hold, VECS[v].sig, int'(VECS[v].lat), 20, 0);
        end

        // R4: dropout at edge 4 restarts the count; done at edge 10
        run_case("R4 dropout", 4'd3, 1'b0, 1'b0, 16'd5, 16'h0008, 10, 20, 1);
        // R5: no ticks for 8 edges, then ticks; done at edge 11
        run_case("R5 tick gate", 4'd3, 1'b0, 1'b0, 16'd2, 16'h0008, 11, 20, 2);
        // R7: state entry at edge 3 restarts the hold of 4; done at edge 8
        run_case("R7 entry mid-hold", 4'd3, 1'b0, 1'b0, 16'd4, 16'h0008, 8, 20, 3);
        // R7: same step entered twice, re-armed each time
        run_case("R7 rearm a", 4'd5, 1'b0, 1'b0, 16'd0, 16'h0020, 1, 10, 0);
        run_case("R7 rearm b", 4'd5, 1'b0, 1'b0, 16'd0, 16'h0020, 1, 10, 0);
        // R9: reset at edge 2 clears the hold of 3; done at edge 6
        run_case("R9 reset mid-hold", 4'd3, 1'b0, 1'b0, 16'd3, 16'h0008, 6, 20, 4);
        // R10: longest hold
        run_case("R10 max hold", 4'd1, 1'b0, 1'b0, 16'd40000, 16'h0002, 40001, 40010, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule